// File: doc/BRIEF.md
# Pipelined Converter Digital Error Correction

This block is the digital back end of a pipelined analog-to-digital converter. Each sample is resolved by nine coarse subconverters. The first eight each produce a 2-bit code that carries one bit of redundancy. The ninth is a plain 2-bit flash. Because successive stages run on alternating clock phases, the codes for one sample arrive spread over several clocks. The block holds each stage's code in its own shift line until all nine codes for the same sample are aligned. It then overlap-adds them into one 10-bit offset-binary word, saturating at full scale when an out-of-range redundant code pushes the sum past the top code.

An optional second lane, Q, runs beside the I lane on the same clock with identical latency. Reset is asynchronous and active low, and its release is synchronised inside the block. After reset, a settling counter holds the valid flag low while the converter's dynamic circuits come up. The testbench stands in for the analog stages and drives digital code sources directly.

Top module: `adc_corr_top`

## Requirements
- R1: Stage k (k = 1..8) drives bits [2k-1:2k-2] of its lane's stage bus. The final flash code has its own 2-bit input, and its code has weight 1.
- R2: The output word equals the sum over k = 1..8 of code_k × 2^(9−k), plus the flash code, in offset binary (0 = negative full scale, 1023 = positive full scale).
- R3: For a given sample, stage k's code is presented floor((k−1)/2) clocks after stage 1's code, and the flash code 4 clocks after it. Codes presented at these offsets are combined as one sample.
- R4: A sample's word appears after the sixth rising edge, counting as the first the edge that captures its stage-1 code. A new word follows on every later edge.
- R5: Codes in which a redundant stage is off by ±1 and the next stage compensates by ∓2 produce exactly the same word as the ideal codes.
- R6: A sum above 1023 is reported as 1023. In particular, stage 1 = 3 with stage 2 ≥ 2 always gives 1023.
- R7: word_valid is low through the 21st rising edge after rst_n rises, high after the 22nd (two edges of reset synchronisation plus 20 settling edges), and stays high afterwards.
- R8: While rst_n is low, both words and word_valid are 0, whatever the inputs.
- R9: The I and Q lanes are independent: each lane's word depends only on its own codes, with the same latency in both.
- R10: All-zero codes give 0000000000, and an ideal mid-scale sample of 512 gives 1000000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock shared by both lanes |
| rst_n | input | 1 | Asynchronous active-low reset |
| i_stage_codes | input | 16 | I lane redundant stage codes, stage k in bits [2k-1:2k-2] |
| i_flash_code | input | 2 | I lane final flash code |
| q_stage_codes | input | 16 | Q lane redundant stage codes, same layout |
| q_flash_code | input | 2 | Q lane final flash code |
| i_word | output | 10 | I lane corrected offset-binary word |
| q_word | output | 10 | Q lane corrected offset-binary word |
| word_valid | output | 1 | High once the settling window has elapsed |

## Verification
The settling counter ending and the saturation clamp can act on the same edge. To provoke this, the bench places an all-threes code set on the I lane as the sample whose word lands on the 22nd edge after reset release. At that edge it places an all-zero sample on the Q lane. It then judges word_valid rising together with an I word of 1023 and a Q word of 0 at that single sampling point. Around that edge, the neighbouring samples are random ideal words, so a shift of either event by one cycle is visible.

// File: rtl/adc_corr_pkg.sv
package adc_corr_pkg;
  localparam int CODE_W = 2;
  typedef logic [CODE_W-1:0] stage_code_t;

  // clocks of arrival skew of stage index j (0-based) behind stage 0
  function automatic int arrival_skew(input int j);
    return j / 2;
  endfunction
endpackage

// File: rtl/adc_corr_rst_sync.sv
module adc_corr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/adc_corr_skew_line.sv
module adc_corr_skew_line #(
  parameter int W     = 2,
  parameter int DEPTH = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] tap_q [DEPTH];
  logic [W-1:0] tap_d [DEPTH];

  always_comb begin
    tap_d[0] = din;
    for (int i = 1; i < DEPTH; i++) tap_d[i] = tap_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) tap_q[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) tap_q[i] <= tap_d[i];
    end
  end

  assign dout = tap_q[DEPTH-1];
endmodule

// File: rtl/adc_corr_lane.sv
module adc_corr_lane
  import adc_corr_pkg::*;
#(
  parameter int NUM_STAGES = 8,
  parameter int OUT_W      = NUM_STAGES + 2,
  parameter int LATENCY    = 6
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_STAGES*CODE_W-1:0] stage_codes,
  input  logic [CODE_W-1:0]            flash_code,
  output logic [OUT_W-1:0]             word
);
  localparam int ALIGN = LATENCY - 1;      // registers before the adder
  localparam int SUM_W = OUT_W + 1;        // one carry bit above full scale

  stage_code_t       aligned [NUM_STAGES+1];
  logic [SUM_W-1:0]  sum_c;
  logic [OUT_W-1:0]  word_d;
  logic [OUT_W-1:0]  word_q;
  logic              red_zero;

  // deskew: earlier stages wait longer so all codes of a sample meet
  for (genvar j = 0; j <= NUM_STAGES; j++) begin : g_stage
    localparam int DEPTH = ALIGN - arrival_skew(j);
    stage_code_t din;
    if (j < NUM_STAGES) begin : g_red
      assign din = stage_codes[j*CODE_W +: CODE_W];
    end else begin : g_flash
      assign din = flash_code;
    end
    adc_corr_skew_line #(.W(CODE_W), .DEPTH(DEPTH)) u_line (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (din),
      .dout (aligned[j])
    );
  end

  // overlap-add: each redundant stage weighs twice its successor
  always_comb begin
    sum_c = SUM_W'(aligned[NUM_STAGES]);
    for (int j = 0; j < NUM_STAGES; j++) begin
      sum_c = sum_c + (SUM_W'(aligned[j]) << (OUT_W - 2 - j));
    end
  end

  // saturate on carry out of the word
  always_comb begin
    if (sum_c[OUT_W]) word_d = {OUT_W{1'b1}};
    else              word_d = sum_c[OUT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else        word_q <= word_d;
  end

  assign word = word_q;

  always_comb begin
    red_zero = 1'b1;
    for (int j = 0; j < NUM_STAGES; j++) red_zero = red_zero & (aligned[j] == '0);
  end

  AST_SAT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (aligned[0] == 2'd3 && aligned[1][1]) |=> (word_q == {OUT_W{1'b1}})); // R6
  AST_FLASH_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    red_zero |=> (word_q == OUT_W'($past(aligned[NUM_STAGES])))); // R2
  AST_ZERO_CODES: assert property (@(posedge clk) disable iff (!rst_n)
    (red_zero && aligned[NUM_STAGES] == '0) |=> (word_q == '0)); // R10
endmodule

// File: rtl/adc_corr_settle.sv
module adc_corr_settle #(
  parameter int SETTLE = 20
) (
  input  logic clk,
  input  logic rst_n,
  output logic valid
);
  localparam int CNT_W = $clog2(SETTLE + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(SETTLE);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = (cnt_q != LIMIT);
    cnt_d  = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign valid = (cnt_q == LIMIT);

  AST_VALID_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> valid); // R7
endmodule

// File: rtl/adc_corr_top.sv
module adc_corr_top
  import adc_corr_pkg::*;
#(
  parameter int NUM_STAGES = 8,
  parameter int OUT_W      = NUM_STAGES + 2,
  parameter int LATENCY    = 6,
  parameter int SETTLE     = 20,
  parameter int LANES      = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_STAGES*2-1:0]   i_stage_codes,
  input  logic [1:0]                i_flash_code,
  input  logic [NUM_STAGES*2-1:0]   q_stage_codes,
  input  logic [1:0]                q_flash_code,
  output logic [OUT_W-1:0]          i_word,
  output logic [OUT_W-1:0]          q_word,
  output logic                      word_valid
);
  logic rst_int_n;

  adc_corr_rst_sync u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_int_n)
  );

  adc_corr_settle #(.SETTLE(SETTLE)) u_settle (
    .clk  (clk),
    .rst_n(rst_int_n),
    .valid(word_valid)
  );

  adc_corr_lane #(.NUM_STAGES(NUM_STAGES), .OUT_W(OUT_W), .LATENCY(LATENCY)) u_lane_i (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .stage_codes(i_stage_codes),
    .flash_code (i_flash_code),
    .word       (i_word)
  );

  if (LANES > 1) begin : g_q
    adc_corr_lane #(.NUM_STAGES(NUM_STAGES), .OUT_W(OUT_W), .LATENCY(LATENCY)) u_lane_q (
      .clk        (clk),
      .rst_n      (rst_int_n),
      .stage_codes(q_stage_codes),
      .flash_code (q_flash_code),
      .word       (q_word)
    );
  end else begin : g_no_q
    assign q_word = '0;
  end
endmodule

// File: tb/adc_corr_top_test.sv
`timescale 1ns/1ps
module adc_corr_top_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] i_stage_codes, q_stage_codes;
  logic [1:0]  i_flash_code, q_flash_code;
  logic [9:0]  i_word, q_word;
  logic        word_valid;

  int checks = 0;
  int errors = 0;
  int edges  = 0;
  bit chk_valid = 0;

  logic [1:0] ci [64][9];
  logic [1:0] cq [64][9];
  int         ei [64];
  int         eq [64];

  adc_corr_top uut (
    .clk(clk), .rst_n(rst_n),
    .i_stage_codes(i_stage_codes), .i_flash_code(i_flash_code),
    .q_stage_codes(q_stage_codes), .q_flash_code(q_flash_code),
    .i_word(i_word), .q_word(q_word), .word_valid(word_valid)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) edges <= 0;
    else        edges <= edges + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic put(input bit lane, input int s, input logic [1:0] c [9], input int e);
    for (int k = 0; k < 9; k++) begin
      if (lane) cq[s][k] = c[k]; else ci[s][k] = c[k];
    end
    if (lane) eq[s] = e; else ei[s] = e;
  endtask

  // ideal redundant codes for value v, with optional compensated +-1 errors
  task automatic make(input bit lane, input int s, input int v, input bit inj);
    logic [1:0] c [9];
    logic [9:0] vv;
    vv = v[9:0];
    c[0] = vv[9:8];
    for (int j = 1; j < 8; j++) c[j] = {1'b0, vv[8-j]};
    c[8] = {1'b0, vv[0]};
    if (inj) begin
      for (int n = 0; n < 6; n++) begin
        int j;
        j = $urandom_range(0, 7);
        if (c[j] > 0 && c[j+1] <= 1) begin
          c[j] = c[j] - 2'd1; c[j+1] = c[j+1] + 2'd2;
        end else if (c[j] < 3 && c[j+1] >= 2) begin
          c[j] = c[j] + 2'd1; c[j+1] = c[j+1] - 2'd2;
        end
      end
    end
    put(lane, s, c, v);
  endtask

  task automatic raw(input bit lane, input int s, input logic [1:0] fill, input int e);
    logic [1:0] c [9];
    for (int k = 0; k < 9; k++) c[k] = fill;
    put(lane, s, c, e);
  endtask

  // drive n samples with per-stage skew, check each word six edges later
  task automatic run_stream(input int n, input string req);
    for (int c = 0; c < n + 6; c++) begin
      @(negedge clk);
      if (c >= 6) begin
        chk(i_word == 10'(ei[c-6]), {req, " I lane"}, i_word, ei[c-6]);
        chk(q_word == 10'(eq[c-6]), {req, " Q lane"}, q_word, eq[c-6]);
      end
      if (chk_valid) chk(word_valid == (edges >= 22), "R7 valid window", word_valid, edges >= 22);
      for (int k = 0; k < 9; k++) begin
        int si;
        logic [1:0] a, b;
        si = c - k / 2;
        a = (si >= 0 && si < n) ? ci[si][k] : 2'd0;
        b = (si >= 0 && si < n) ? cq[si][k] : 2'd0;
        if (k < 8) begin
          i_stage_codes[k*2 +: 2] = a;
          q_stage_codes[k*2 +: 2] = b;
        end else begin
          i_flash_code = a;
          q_flash_code = b;
        end
      end
    end
    @(negedge clk);
    i_stage_codes = '0; q_stage_codes = '0; i_flash_code = '0; q_flash_code = '0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    i_stage_codes = 16'hFFFF; q_stage_codes = 16'hAAAA;
    i_flash_code = 2'd3; q_flash_code = 2'd2;
    repeat (5) @(negedge clk);
    chk(i_word == 0, "R8 I word in reset", i_word, 0);
    chk(q_word == 0, "R8 Q word in reset", q_word, 0);
    chk(word_valid == 0, "R8 valid in reset", word_valid, 0);
    i_stage_codes = '0; q_stage_codes = '0; i_flash_code = '0; q_flash_code = '0;
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // settling end and saturation on the same edge (sample 14 lands on edge 22)
  task automatic t_settle;
    for (int s = 0; s < 20; s++) begin
      make(0, s, $urandom_range(0, 1023), 0);
      make(1, s, $urandom_range(0, 1023), 0);
    end
    raw(0, 14, 2'd3, 1023);   // R6
    raw(1, 14, 2'd0, 0);      // R10
    chk_valid = 1;
    run_stream(20, "R4 latency");
    chk_valid = 0;
    chk(word_valid == 1, "R7 valid held", word_valid, 1);
  endtask

  task automatic t_ideal;
    for (int s = 0; s < 32; s++) begin
      make(0, s, $urandom_range(0, 1023), 0);
      make(1, s, $urandom_range(0, 1023), 0);
    end
    make(0, 0, 512, 0);       // R10 mid-scale
    make(1, 0, 0, 0);         // R10 negative full scale
    make(0, 1, 1023, 0);
    make(1, 1, 1, 0);
    run_stream(32, "R2 ideal");
  endtask

  // R1 and R3: one stage at a time carries code 1, back to back
  task automatic t_weights;
    for (int s = 0; s < 9; s++) begin
      logic [1:0] c [9];
      for (int k = 0; k < 9; k++) c[k] = (k == s) ? 2'd1 : 2'd0;
      put(0, s, c, (s < 8) ? (1 << (8 - s)) : 1);
      for (int k = 0; k < 9; k++) c[k] = (k == 8 - s) ? 2'd2 : 2'd0;
      put(1, s, c, (s > 0) ? (2 << s) : 2);
    end
    run_stream(9, "R1 R3 stage weight");
  endtask

  task automatic t_redundant;
    for (int s = 0; s < 40; s++) begin
      make(0, s, $urandom_range(0, 1023), 1);
      make(1, s, $urandom_range(0, 1023), 1);
    end
    make(0, 0, 1023, 1);
    make(1, 0, 0, 1);
    run_stream(40, "R5 redundancy");
  endtask

  task automatic t_saturate;
    logic [1:0] c [9];
    raw(0, 0, 2'd3, 1023);
    make(1, 0, 300, 0);       // R9 Q unaffected by I overflow
    for (int k = 0; k < 9; k++) c[k] = 2'd0;
    c[0] = 2'd3; c[1] = 2'd2;
    put(0, 1, c, 1023);       // exactly 1024 before the clamp
    raw(1, 1, 2'd3, 1023);
    c[1] = 2'd1; c[8] = 2'd3;
    put(0, 2, c, 899);        // just below the clamp
    make(1, 2, 700, 1);
    c[1] = 2'd1; for (int k = 2; k < 9; k++) c[k] = 2'd3;
    put(0, 3, c, 1023);       // 1277 before the clamp
    raw(1, 3, 2'd0, 0);
    run_stream(4, "R6 R9 saturation");
  endtask

  initial begin
    t_reset();
    t_settle();
    t_ideal();
    t_weights();
    t_redundant();
    t_saturate();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule